// File: doc/BRIEF.md
# Quad-Lane Serial Sample Framer

This block turns four parallel sample words, one per channel, into four one-bit serial lanes, together with a bit clock and a frame marker that a receiver uses to rebuild the words. It runs on a fast clock with one bit period per enabled cycle. The `bit_en` input stands in for the rate multiplier that would normally produce that fast clock. When a frame ends, the next enabled cycle captures every channel's word and starts a new frame. Changes on the sample inputs during a frame have no effect until the following frame starts.

Frame length, bit order, output polarity and per-lane or whole-block shutdown can all be changed while the block runs. Bit order and frame length are sampled when a frame starts, so a frame in progress is never reshaped. Polarity applies at once. Output enables stand in for the high-impedance state of real output drivers. Samples are offset binary and pass through unchanged: midscale `10'b1000000000`, full positive scale all ones, full negative scale all zeros.

Top module: `adcfr_top`

## Requirements
- R1: Each lane carries the word of its own channel, one bit per enabled cycle, with channel i on lane i (channel i's sample in bits `[10*i+9:10*i]` of `sample_bus`). The word is captured in the cycle that starts the frame, and later changes on `sample_bus` do not alter that frame.
- R2: With `lsb_first`=0, sample bit 9 is sent first and bit 0 last. With `lsb_first`=1 the order is reversed. The setting is sampled at frame start.
- R3: `bclk_out` is 1 in the first bit period of a frame and toggles every bit period, giving 5 bit-clock periods per 10-bit frame and 6 per 12-bit frame.
- R4: `frame_out` is 1 for the first half of each frame (bit periods 0..4 of 10, or 0..5 of 12) and 0 for the rest. It rises together with the first bit.
- R5: With `res_wide`=0 a frame lasts 10 bit periods. With `res_wide`=1 it lasts 12, and the two extra bits are zeros. They follow the data in MSB-first order and precede it in LSB-first order. The setting is sampled at frame start.
- R6: In a cycle with `bit_en`=0, no lane, bit-clock or frame output changes.
- R7: `invert`=1 inverts every lane bit, padding included, in the same cycle. It does not affect `bclk_out` or `frame_out`.
- R8: While `pwr_down`=1, all lane enables, `bclk_oe` and `frame_oe` are 0. Framing stops, and the first enabled cycle after release starts a new frame.
- R9: `lane_off[i]`=1 drives `lane_oe[i]` to 0 and leaves the other lanes and the clocks unaffected.
- R10: After reset, `bclk_out` and `frame_out` are 0 and the lanes idle at the `invert` level until the first enabled cycle, which starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Advances the stream by one bit period |
| sample_bus | input | 40 | Four 10-bit offset-binary samples, channel i in bits [10*i+9:10*i] |
| lsb_first | input | 1 | 1 selects least-significant-bit-first order |
| res_wide | input | 1 | 1 selects 12-bit frames |
| invert | input | 1 | Inverts lane data |
| pwr_down | input | 1 | Whole-block shutdown |
| lane_off | input | 4 | Per-lane shutdown |
| lane_dout | output | 4 | Serial lane data |
| lane_oe | output | 4 | Lane output enables |
| bclk_out | output | 1 | Bit clock, one edge per bit |
| bclk_oe | output | 1 | Bit clock output enable |
| frame_out | output | 1 | Frame marker |
| frame_oe | output | 1 | Frame marker output enable |

## Verification
Several properties are checked on every cycle: bit-clock toggling and freezing, the frame marker and bit clock both rising on a frame's first bit, idle after shutdown, one-place shifting, and zero padding on the correct side of the word. What only the bench scenarios can show is that the bits recovered on each lane match the captured samples. This is checked in all four combinations of order and length, with bit-order and length changes landing mid-frame, polarity flipped at arbitrary points, gaps in `bit_en`, and lanes or the whole block switched off and back on. A behavioural model in the bench predicts every output in every cycle.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;
  localparam int DEF_LANES    = 4;
  localparam int DEF_SAMPLE_W = 10;
  localparam int DEF_PAD_W    = 2;

  typedef struct packed {
    logic lsb_first;
    logic res_wide;
  } frame_fmt_t;
endpackage

// File: rtl/adcfr_rst_sync.sv
module adcfr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/adcfr_timing.sv
module adcfr_timing #(
  parameter int SAMPLE_W = adcfr_pkg::DEF_SAMPLE_W,
  parameter int PAD_W    = adcfr_pkg::DEF_PAD_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic pwr_down,
  input  logic res_wide,
  output logic load_o,
  output logic shift_o,
  output logic bclk_o,
  output logic frame_o
);
  localparam int FW = SAMPLE_W + PAD_W;
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST_N = CW'(SAMPLE_W - 1);
  localparam logic [CW-1:0] LAST_W = CW'(FW - 1);
  localparam logic [CW-1:0] HALF_N = CW'(SAMPLE_W / 2);
  localparam logic [CW-1:0] HALF_W = CW'(FW / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          res_q, res_d;
  logic [CW-1:0] last_idx, half_idx;

  always_comb begin
    last_idx = res_q ? LAST_W : LAST_N;
    half_idx = res_q ? HALF_W : HALF_N;
    load_o   = bit_en && !pwr_down && (!run_q || (cnt_q == last_idx));
    shift_o  = bit_en && !pwr_down && run_q && !load_o;
    cnt_d = cnt_q;
    run_d = run_q;
    res_d = res_q;
    if (pwr_down) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (load_o) begin
      cnt_d = '0;
      run_d = 1'b1;
      res_d = res_wide;
    end else if (shift_o) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      res_q <= res_d;
    end
  end

  assign bclk_o  = run_q & ~cnt_q[0];
  assign frame_o = run_q & (cnt_q < half_idx);

  // R4: both markers high on the first bit of every frame
  p_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (frame_o && bclk_o));
  // R3: bit clock toggles on every advancing bit inside a frame
  p_bclk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> (bclk_o != $past(bclk_o)));
  // R6: no advance without the enable
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !pwr_down) |=> ($stable(cnt_q) && $stable(run_q)));
  // R8: shutdown leaves framing idle
  p_pd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!run_q && !frame_o && !bclk_o));
  // R5: position never passes the frame's last bit
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= last_idx));
endmodule

// File: rtl/adcfr_lane.sv
module adcfr_lane #(
  parameter int SAMPLE_W = adcfr_pkg::DEF_SAMPLE_W,
  parameter int PAD_W    = adcfr_pkg::DEF_PAD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      shift,
  input  adcfr_pkg::frame_fmt_t     fmt,
  input  logic                      invert,
  input  logic [SAMPLE_W-1:0]       sample,
  output logic                      dout
);
  localparam int FW = SAMPLE_W + PAD_W;

  logic [FW-1:0]       shreg_q, shreg_d;
  logic [SAMPLE_W-1:0] rev;
  logic [FW-1:0]       word;

  always_comb begin
    for (int k = 0; k < SAMPLE_W; k++) rev[k] = sample[SAMPLE_W-1-k];
    if (!fmt.lsb_first)    word = {sample, {PAD_W{1'b0}}};
    else if (fmt.res_wide) word = {{PAD_W{1'b0}}, rev};
    else                   word = {rev, {PAD_W{1'b0}}};
    shreg_d = shreg_q;
    if (load)       shreg_d = word;
    else if (shift) shreg_d = {shreg_q[FW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign dout = shreg_q[FW-1] ^ invert;

  // R1: stream advances exactly one place per shifting bit
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (shreg_q[FW-1] == $past(shreg_q[FW-2])));
  // R6: stored word frozen when neither loading nor shifting
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(shreg_q));
  // R5: padding trails the data in MSB-first wide frames
  p_pad_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && fmt.res_wide && !fmt.lsb_first) |=> (shreg_q[PAD_W-1:0] == '0));
  // R5: padding leads the data in LSB-first wide frames
  p_pad_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && fmt.res_wide && fmt.lsb_first) |=> (shreg_q[FW-1 -: PAD_W] == '0));
endmodule

// File: rtl/adcfr_top.sv
module adcfr_top #(
  parameter int LANES    = adcfr_pkg::DEF_LANES,
  parameter int SAMPLE_W = adcfr_pkg::DEF_SAMPLE_W,
  parameter int PAD_W    = adcfr_pkg::DEF_PAD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic [LANES*SAMPLE_W-1:0] sample_bus,
  input  logic                      lsb_first,
  input  logic                      res_wide,
  input  logic                      invert,
  input  logic                      pwr_down,
  input  logic [LANES-1:0]          lane_off,
  output logic [LANES-1:0]          lane_dout,
  output logic [LANES-1:0]          lane_oe,
  output logic                      bclk_out,
  output logic                      bclk_oe,
  output logic                      frame_out,
  output logic                      frame_oe
);
  logic                  rst_int_n;
  logic                  load, shift;
  adcfr_pkg::frame_fmt_t fmt;

  assign fmt.lsb_first = lsb_first;
  assign fmt.res_wide  = res_wide;

  adcfr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  adcfr_timing #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) u_timing (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .pwr_down (pwr_down),
    .res_wide (res_wide),
    .load_o   (load),
    .shift_o  (shift),
    .bclk_o   (bclk_out),
    .frame_o  (frame_out)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adcfr_lane #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .load   (load),
      .shift  (shift),
      .fmt    (fmt),
      .invert (invert),
      .sample (sample_bus[g*SAMPLE_W +: SAMPLE_W]),
      .dout   (lane_dout[g])
    );
    assign lane_oe[g] = ~pwr_down & ~lane_off[g];
  end

  assign bclk_oe  = ~pwr_down;
  assign frame_oe = ~pwr_down;
endmodule

// File: tb/tb_adcfr_top.sv
module tb_adcfr_top;
  localparam int LANES = 4;
  localparam int SW    = 10;
  localparam int FWM   = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   rst_n, bit_en, lsb_first, res_wide, invert, pwr_down;
  logic [LANES*SW-1:0]    sample_bus;
  logic [LANES-1:0]       lane_off, lane_dout, lane_oe;
  logic                   bclk_out, bclk_oe, frame_out, frame_oe;

  adcfr_top dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sample_bus(sample_bus),
    .lsb_first(lsb_first), .res_wide(res_wide), .invert(invert),
    .pwr_down(pwr_down), .lane_off(lane_off), .lane_dout(lane_dout),
    .lane_oe(lane_oe), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .frame_out(frame_out), .frame_oe(frame_oe)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  int   pos   = -1;
  int   flen  = 10;
  logic xbits [LANES][FWM];

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: frame position and captured bits per lane
  always @(posedge clk) begin
    if (!rst_n || pwr_down) pos = -1;
    else if (bit_en) begin
      if (pos < 0 || pos == flen - 1) begin
        flen = res_wide ? 12 : 10;
        for (int l = 0; l < LANES; l++) begin
          for (int k = 0; k < FWM; k++) begin
            logic [SW-1:0] s;
            s = sample_bus[l*SW +: SW];
            if (!res_wide)      xbits[l][k] = (k < 10) ? (lsb_first ? s[k] : s[9-k]) : 1'b0;
            else if (!lsb_first) xbits[l][k] = (k < 10) ? s[9-k] : 1'b0;
            else                xbits[l][k] = (k < 2) ? 1'b0 : s[k-2];
          end
        end
        pos = 0;
      end else pos++;
    end
  end

  task automatic compare_all();
    for (int l = 0; l < LANES; l++) begin
      logic oe_x;
      oe_x = !pwr_down && !lane_off[l];
      chk("R8 R9 lane_oe", lane_oe[l], oe_x);
      if (pos >= 0 && oe_x)
        chk("R1 R2 R5 R7 lane data", lane_dout[l], xbits[l][pos] ^ invert);
    end
    chk("R8 bclk_oe", bclk_oe, !pwr_down);
    chk("R8 frame_oe", frame_oe, !pwr_down);
    chk("R3 R6 bclk_out", bclk_out, (pos >= 0) && (pos % 2 == 0));
    chk("R4 R6 frame_out", frame_out, (pos >= 0) && (pos < flen / 2));
  endtask

  function automatic logic [SW-1:0] pick();
    case ($urandom_range(7))
      0: return 10'h200;
      1: return 10'h3FF;
      2: return 10'h000;
      3: return 10'h155;
      default: return SW'($urandom);
    endcase
  endfunction

  task automatic cycle(input int en_pct);
    @(negedge clk);
    compare_all();
    bit_en = ($urandom_range(99) < en_pct);
    for (int l = 0; l < LANES; l++) sample_bus[l*SW +: SW] = pick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; lsb_first = 1'b0; res_wide = 1'b0;
    invert = 1'b0; pwr_down = 1'b0; lane_off = '0; sample_bus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: idle state after reset
    chk("R10 reset bclk_out", bclk_out, 1'b0);
    chk("R10 reset frame_out", frame_out, 1'b0);
    for (int l = 0; l < LANES; l++) chk("R10 reset lane_dout", lane_dout[l], 1'b0);

    // R1 R2 R5: all four order/length combinations, full rate then gapped
    for (int m = 0; m < 4; m++) begin
      lsb_first = m[0];
      res_wide  = m[1];
      repeat (250) cycle(100);
      repeat (150) cycle(70);
    end
    // R7: polarity flips at arbitrary points
    for (int i = 0; i < 8; i++) begin
      invert = ~invert;
      repeat ($urandom_range(5, 40)) cycle(90);
    end
    invert = 1'b0;
    // R2 R5: format changes landing mid-frame
    for (int i = 0; i < 25; i++) begin
      lsb_first = 1'($urandom);
      res_wide  = 1'($urandom);
      repeat ($urandom_range(3, 17)) cycle(85);
    end
    // R9: individual lanes off
    lane_off = 4'b0101; repeat (120) cycle(95);
    lane_off = 4'b1110; repeat (120) cycle(95);
    lane_off = 4'b0000;
    // R8: whole-block shutdown and restart
    for (int i = 0; i < 6; i++) begin
      pwr_down = 1'b1;
      repeat ($urandom_range(1, 12)) cycle(80);
      pwr_down = 1'b0;
      repeat ($urandom_range(20, 60)) cycle(90);
    end
    repeat (50) cycle(100);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule